// File: doc/BRIEF.md
# Serial Audio Transmitter Control and Status Register

This block is the control and status word of a serial audio transmitter. Software reaches it through a simple 32-bit bus. A write takes effect on the clock edge where `wr_en` is high. The read value on `rd_data` always shows the current register state. The block drives the enable and reset levels that the transmit datapath consumes. It also collects sticky event flags that the datapath reports.

Two controls do not act at once. Turning off the bit clock, and halting the transmitter for debug, both wait for the frame that is in progress to finish, which the datapath marks with a one-cycle `frame_end` pulse. Turning on the transmitter always turns on the bit clock in the same write. The FIFO pointer reset is a self-clearing command that reads back as zero. The software reset is a level that holds the transmit logic in reset and keeps the status flags clear.

Top module: `tx_ctrl_status`

## Requirements
- R1: A write with bit 31 (transmit enable) set to 1 sets bit 28 (bit-clock enable) to 1 and drives `bclk_en` high from the next cycle, whatever bit 28 of the written data is.
- R2: A write that leaves bits 31 and 28 both 0 while the bit clock runs does not stop it. Bit 28 keeps reading 1 and `bclk_en` stays high until the first `frame_end` pulse in a later cycle. At that pulse both clear together.
- R3: A write of 1 to bit 31 or bit 28 while a disable is pending cancels the pending disable. A later `frame_end` then leaves the bit clock running.
- R4: A write with bit 25 set produces a `fifo_ptr_rst` pulse exactly one cycle long, in the cycle after the write. Bit 25 always reads 0.
- R5: Bit 24 (software reset) is read/write and drives `tx_soft_rst`. The write that sets it clears bits 20, 19 and 18. While it stays 1, those flags stay 0 and flag events are ignored. Bits 31, 30 and 28 keep their values.
- R6: Bits 20 (word start), 19 (frame sync error) and 18 (FIFO underrun) are sticky. Each is set by a pulse on its event input and is cleared only by a write with a 1 in that bit position. Writing 0 there has no effect.
- R7: If a flag's event and a clearing write of that flag fall in the same cycle, the flag ends up 1.
- R8: Bit 30 is the debug enable. With bit 30 at 0 and `debug_mode` high, `tx_active` stays high until the next `frame_end`, then goes low and stays low while `debug_mode` is high. With bit 30 at 1, debug mode does not stop the transmitter. `tx_active` returns once `debug_mode` falls.
- R9: `debug_mode` never affects `bclk_en` or bit 28.
- R10: Bits 27, 26, 23, 22, 21 and 17 to 0 always read 0 and ignore writes.
- R11: After reset, `rd_data` is 0 and all outputs are low. `tx_active` is high only when bit 31 is 1 and the transmitter is not halted for debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| frame_end | input | 1 | One-cycle pulse at the end of each transmit frame |
| debug_mode | input | 1 | Chip debug mode level |
| word_start_evt | input | 1 | Start-of-word detected pulse |
| sync_err_evt | input | 1 | Frame sync error pulse |
| underrun_evt | input | 1 | FIFO underrun pulse |
| bclk_en | output | 1 | Transmit bit-clock enable |
| tx_active | output | 1 | Transmitter running level |
| fifo_ptr_rst | output | 1 | One-cycle FIFO pointer reset pulse |
| tx_soft_rst | output | 1 | Transmit logic reset level |

## Verification
The bench targets the boundaries of the deferred disable.

- It checks that bit 28 still reads 1 in the idle cycles after the clearing write, and that it drops exactly on the `frame_end` edge. A design that clears at once would lose the tail of the frame.
- It re-enables the transmitter before the frame ends. A design that keeps a stale pending flag would cut the clock after software asked for it to stay on.
- It clears a flag in the same cycle as that flag's event, and writes zeros over set flags. A design with the wrong priority loses an underrun or sync error.
- It enters debug mode with the debug enable both clear and set, and watches that `bclk_en` never drops. A design that gates the clock with debug would starve the external bit clock.

// File: rtl/tx_csr_pkg.sv
// Package: shared bit positions and widths for the transmitter control word.
// Assumes a 32-bit register; every field position below is fixed by software.
package tx_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 3;

    localparam int POS_TE    = 31;
    localparam int POS_DBGE  = 30;
    localparam int POS_BCE   = 28;
    localparam int POS_FPR   = 25;
    localparam int POS_SRST  = 24;
    localparam int POS_FLAG0 = 18;   // flags occupy POS_FLAG0 .. POS_FLAG0+NUM_FLAGS-1

    // Flag index order inside the flag vector (lowest bit first).
    localparam int FLG_UNDERRUN = 0;
    localparam int FLG_SYNCERR  = 1;
    localparam int FLG_WORDST   = 2;
endpackage

// File: rtl/tx_csr_bclk.sv
// Module: bit-clock enable with deferred disable.
// Setting the transmit enable or the clock enable turns the clock on at once.
// A write that clears both only arms a pending disable, which completes on the
// next frame_end pulse in a later cycle. A new set cancels the pending disable.
// Assumes frame_end is a single-cycle pulse synchronous to clk.
module tx_csr_bclk (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_te,
    input  logic wr_bce,
    input  logic frame_end,
    output logic bce
);
    logic bce_q;
    logic pend_q;

    // Purpose: track the clock enable and its pending-disable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bce_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (wr_en && (wr_te || wr_bce)) begin
            bce_q  <= 1'b1;
            pend_q <= 1'b0;
        end else if (pend_q && frame_end) begin
            bce_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (wr_en && bce_q) begin
            pend_q <= 1'b1;
        end
    end

    assign bce = bce_q;
endmodule

// File: rtl/tx_csr_dbg.sv
// Module: debug halt of the transmitter.
// When debug mode is entered without the debug enable, the transmitter halts
// at the next frame boundary. Leaving debug mode, or setting the enable,
// releases the halt at once. The bit clock is never touched here.
module tx_csr_dbg (
    input  logic clk,
    input  logic rst_n,
    input  logic te,
    input  logic dbg_en,
    input  logic debug_mode,
    input  logic frame_end,
    output logic active
);
    logic halt_q;

    // Purpose: hold the halt state from a frame boundary until debug ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (!debug_mode || dbg_en) begin
            halt_q <= 1'b0;
        end else if (frame_end) begin
            halt_q <= 1'b1;
        end
    end

    assign active = te && !halt_q;
endmodule

// File: rtl/tx_csr_flags.sv
// Module: bank of sticky write-one-to-clear flags.
// Each flag is set by its event, cleared by a 1 in its clear bit, and forced
// to 0 while hold_clr is high. An event wins over a clear in the same cycle.
module tx_csr_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_clr,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;

        // Purpose: one sticky flag with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n || hold_clr) begin
                f_q <= 1'b0;
            end else if (evt[i]) begin
                f_q <= 1'b1;
            end else if (clr[i]) begin
                f_q <= 1'b0;
            end
        end

        assign flags[i] = f_q;
    end
endmodule

// File: rtl/tx_ctrl_status.sv
// Module: transmitter control/status register (top).
// Decodes single-cycle writes, holds the plain control bits, produces the
// FIFO pointer reset pulse and assembles the read word. Reserved bits read 0.
// Assumes wr_en is high for one cycle per write and rd_data is sampled freely.
module tx_ctrl_status
    import tx_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    input  logic              debug_mode,
    input  logic              word_start_evt,
    input  logic              sync_err_evt,
    input  logic              underrun_evt,
    output logic              bclk_en,
    output logic              tx_active,
    output logic              fifo_ptr_rst,
    output logic              tx_soft_rst
);
    localparam int FLAG_HI = POS_FLAG0 + NUM_FLAGS - 1;

    logic                 te_q;
    logic                 dbge_q;
    logic                 srst_q;
    logic                 fpr_q;
    logic                 bce;
    logic                 clr_hold;
    logic [NUM_FLAGS-1:0] evt_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;

    // Purpose: plain read/write control bits and the self-clearing FIFO reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q   <= 1'b0;
            dbge_q <= 1'b0;
            srst_q <= 1'b0;
            fpr_q  <= 1'b0;
        end else begin
            fpr_q <= wr_en && wr_data[POS_FPR];
            if (wr_en) begin
                te_q   <= wr_data[POS_TE];
                dbge_q <= wr_data[POS_DBGE];
                srst_q <= wr_data[POS_SRST];
            end
        end
    end

    // Purpose: gather flag events and clear requests into vectors.
    always_comb begin
        evt_vec = '0;
        evt_vec[FLG_UNDERRUN] = underrun_evt;
        evt_vec[FLG_SYNCERR]  = sync_err_evt;
        evt_vec[FLG_WORDST]   = word_start_evt;
        clr_vec  = wr_en ? wr_data[FLAG_HI:POS_FLAG0] : '0;
        clr_hold = srst_q || (wr_en && wr_data[POS_SRST]);
    end

    tx_csr_bclk u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_te     (wr_data[POS_TE]),
        .wr_bce    (wr_data[POS_BCE]),
        .frame_end (frame_end),
        .bce       (bce)
    );

    tx_csr_dbg u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .te         (te_q),
        .dbg_en     (dbge_q),
        .debug_mode (debug_mode),
        .frame_end  (frame_end),
        .active     (tx_active)
    );

    tx_csr_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (clr_hold),
        .evt      (evt_vec),
        .clr      (clr_vec),
        .flags    (flags)
    );

    // Purpose: assemble the read word; every other bit is reserved and reads 0.
    always_comb begin
        rd_data                    = '0;
        rd_data[POS_TE]            = te_q;
        rd_data[POS_DBGE]          = dbge_q;
        rd_data[POS_BCE]           = bce;
        rd_data[POS_SRST]          = srst_q;
        rd_data[FLAG_HI:POS_FLAG0] = flags;
    end

    assign bclk_en      = bce;
    assign fifo_ptr_rst = fpr_q;
    assign tx_soft_rst  = srst_q;
endmodule

// File: rtl/tx_ctrl_status_chk.sv
// Module: assertion checker for tx_ctrl_status, attached by bind below.
// Assumes the field positions of tx_csr_pkg.
module tx_ctrl_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        frame_end,
    input logic        word_start_evt,
    input logic        bclk_en,
    input logic        tx_active,
    input logic        fifo_ptr_rst,
    input logic        tx_soft_rst
);
    AST_TE_FORCES_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[31] |=> bclk_en && rd_data[28]);                    // R1
    AST_BCLK_HOLDS_TO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en && !frame_end |=> bclk_en);                                  // R2
    AST_FPR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[25] |=> fifo_ptr_rst);                              // R4
    AST_FPR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ptr_rst && !$past(wr_en) |-> 1'b0);                             // R4
    AST_FPR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[25] == 1'b0);                                                // R4
    AST_SRST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soft_rst |-> rd_data[20:18] == 3'b000);                           // R5
    AST_WORD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_evt && !tx_soft_rst && !(wr_en && wr_data[24]) |=> rd_data[20]); // R7
    AST_ACTIVE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> $past(wr_en) || $past(frame_end));              // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[27:26] == 2'b00 && rd_data[23:21] == 3'b000 && rd_data[17:0] == 18'd0); // R10
endmodule

bind tx_ctrl_status tx_ctrl_status_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .frame_end      (frame_end),
    .word_start_evt (word_start_evt),
    .bclk_en        (bclk_en),
    .tx_active      (tx_active),
    .fifo_ptr_rst   (fifo_ptr_rst),
    .tx_soft_rst    (tx_soft_rst)
);

// File: tb/sim_tx_ctrl_status.sv
// Bench: scoreboard for tx_ctrl_status. The driver applies one cycle of
// stimulus and pushes the expected outputs; the monitor compares at negedge.
module sim_tx_ctrl_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        frame_end = 1'b0;
    logic        debug_mode = 1'b0;
    logic        word_start_evt = 1'b0;
    logic        sync_err_evt = 1'b0;
    logic        underrun_evt = 1'b0;
    logic        bclk_en, tx_active, fifo_ptr_rst, tx_soft_rst;

    int   n_run = 0;
    int   n_fail = 0;
    logic dbg_lvl = 1'b0;
    bit   done = 1'b0;

    localparam logic [3:0] FE = 4'b1000, WS = 4'b0100, SE = 4'b0010, UF = 4'b0001;

    typedef struct {
        string       req;
        logic [31:0] rd;
        logic        bclk, act, fpr, srst;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    tx_ctrl_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .frame_end(frame_end), .debug_mode(debug_mode), .word_start_evt(word_start_evt),
        .sync_err_evt(sync_err_evt), .underrun_evt(underrun_evt), .bclk_en(bclk_en),
        .tx_active(tx_active), .fifo_ptr_rst(fifo_ptr_rst), .tx_soft_rst(tx_soft_rst)
    );

    // Driver: one clock of stimulus.
    task automatic step(input logic w, input logic [31:0] d, input logic [3:0] ev);
        @(negedge clk);
        wr_en = w; wr_data = d; debug_mode = dbg_lvl;
        {frame_end, word_start_evt, sync_err_evt, underrun_evt} = ev;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [31:0] rd,
                              input logic bclk, input logic act,
                              input logic fpr, input logic srst);
        exp_t e;
        e.req = req; e.rd = rd; e.bclk = bclk; e.act = act; e.fpr = fpr; e.srst = srst;
        q.push_back(e);
    endtask

    // Monitor: compare outputs against queued expectations.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (rd_data !== e.rd || bclk_en !== e.bclk || tx_active !== e.act ||
                fifo_ptr_rst !== e.fpr || tx_soft_rst !== e.srst) begin
                n_fail++;
                $display("FAIL %s: got rd=%h bclk=%b act=%b fpr=%b srst=%b, exp rd=%h bclk=%b act=%b fpr=%b srst=%b",
                         e.req, rd_data, bclk_en, tx_active, fifo_ptr_rst, tx_soft_rst,
                         e.rd, e.bclk, e.act, e.fpr, e.srst);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        expect_out("R11 reset", 32'h0, 0, 0, 0, 0);

        step(1, 32'h8000_0000, 0); expect_out("R1 te sets bce", 32'h9000_0000, 1, 1, 0, 0);
        step(1, 32'h0, 0);         expect_out("R2 disable deferred", 32'h1000_0000, 1, 0, 0, 0);
        step(0, 32'h0, 0);         expect_out("R2 still running", 32'h1000_0000, 1, 0, 0, 0);
        step(0, 32'h0, FE);        expect_out("R2 cleared at frame end", 32'h0, 0, 0, 0, 0);

        step(1, 32'h8000_0000, 0); expect_out("R1 re-enable", 32'h9000_0000, 1, 1, 0, 0);
        step(1, 32'h0, 0);         expect_out("R3 pending", 32'h1000_0000, 1, 0, 0, 0);
        step(1, 32'h8000_0000, 0); expect_out("R3 cancel", 32'h9000_0000, 1, 1, 0, 0);
        step(0, 32'h0, FE);        expect_out("R3 frame end kept", 32'h9000_0000, 1, 1, 0, 0);
        step(1, 32'h0, FE);        expect_out("R2 same-cycle frame end ignored", 32'h1000_0000, 1, 0, 0, 0);
        step(0, 32'h0, FE);        expect_out("R2 later frame end", 32'h0, 0, 0, 0, 0);

        step(1, 32'h0200_0000, 0); expect_out("R4 pulse", 32'h0, 0, 0, 1, 0);
        step(0, 32'h0, 0);         expect_out("R4 pulse ends", 32'h0, 0, 0, 0, 0);

        step(1, 32'h0CE0_0000, 0); expect_out("R10 reserved", 32'h0, 0, 0, 0, 0);

        step(0, 32'h0, WS);        expect_out("R6 word start", 32'h0010_0000, 0, 0, 0, 0);
        step(0, 32'h0, SE | UF);   expect_out("R6 sync and underrun", 32'h001C_0000, 0, 0, 0, 0);
        step(1, 32'h0, 0);         expect_out("R6 write 0 no effect", 32'h001C_0000, 0, 0, 0, 0);
        step(1, 32'h0008_0000, 0); expect_out("R6 w1c sync", 32'h0014_0000, 0, 0, 0, 0);
        step(1, 32'h0010_0000, WS); expect_out("R7 set wins", 32'h0014_0000, 0, 0, 0, 0);
        step(1, 32'h0014_0000, 0); expect_out("R6 w1c both", 32'h0, 0, 0, 0, 0);

        step(0, 32'h0, WS | SE | UF); expect_out("R6 all set", 32'h001C_0000, 0, 0, 0, 0);
        step(1, 32'hC100_0000, 0); expect_out("R5 soft reset clears flags", 32'hD100_0000, 1, 1, 0, 1);
        step(0, 32'h0, WS | UF);   expect_out("R5 events ignored", 32'hD100_0000, 1, 1, 0, 1);
        step(1, 32'hC000_0000, 0); expect_out("R5 release", 32'hD000_0000, 1, 1, 0, 0);

        dbg_lvl = 1'b1;
        step(0, 32'h0, FE);        expect_out("R8 debug enabled keeps running", 32'hD000_0000, 1, 1, 0, 0);
        step(1, 32'h8000_0000, 0); expect_out("R8 frame finishes", 32'h9000_0000, 1, 1, 0, 0);
        step(0, 32'h0, FE);        expect_out("R9 halted, clock on", 32'h9000_0000, 1, 0, 0, 0);
        step(0, 32'h0, 0);         expect_out("R9 halt holds", 32'h9000_0000, 1, 0, 0, 0);
        dbg_lvl = 1'b0;
        step(0, 32'h0, 0);         expect_out("R8 resume", 32'h9000_0000, 1, 1, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule